// File: doc/BRIEF.md
# Microcontroller Status and Power Flag Register

This block is the status byte of a small 8-bit microcontroller core. It keeps the three ALU result flags (zero, nibble carry, carry) and two program-page select bits. It also keeps two power-management flags. The time-out flag shows whether the watchdog has fired. The power-down flag shows whether the core went to sleep. The top bit is not stored: it passes the live comparator level straight through.

The power-management flags are not ordinary data bits. The CPU cannot write them. They change only on the one-cycle strobes from the sleep and watchdog-clear instructions, on a watchdog time-out pulse, and on power-on. After a watchdog-triggered restart, software reads them to learn why the core started.

The block has two resets. The power-on reset `porN` is asynchronous and active low. It loads the whole register to its power-up value. The core reset `rstN` is synchronous and active low. It clears the page and ALU flags but keeps the time-out and power-down flags, so the reset cause survives it.

Top module: `mcu_status_reg`

## Requirements
- R1: While `porN` is low the register reads T=1 (bit 4), P=1 (bit 3), page bits 6:5 = 0, Z/DC/C (bits 2:0) = 0. With the comparator low, `statusOut` = 8'h18.
- R2: A `wdtTimeout` pulse clears T at the next clock edge. It wins over a sleep or watchdog-clear strobe in the same cycle, and it also acts while `rstN` is low.
- R3: A `sleepStb` cycle sets T to 1 and clears P to 0 at the next clock edge.
- R4: A `wdtClrStb` cycle sets T and P to 1. When `sleepStb` is also high in that cycle, P is cleared: sleep wins for P.
- R5: `aluFlags` is ordered {Z, DC, C}, and `aluFlagEn` uses the same order. Each flag whose enable is high loads its ALU value into status bits 2, 1 and 0 respectively. A flag whose enable is low holds its value.
- R6: A `cpuWrEn` cycle loads `cpuWrData[6:5]` into the page bits and `cpuWrData[2:0]` into Z, DC and C. Bits 7, 4 and 3 of the write data are ignored.
- R7: When a CPU write and ALU flag enables occur in the same cycle, the three flags take the CPU write data.
- R8: `statusOut[7]` equals `cmpIn` in the same cycle, with no register in the path.
- R9: `pageSel` always equals `statusOut[6:5]`. Bit 6 is the upper page bit.
- R10: A cycle with `rstN` low clears the page bits and Z, DC and C. It keeps T and P, and ignores sleep strobes, watchdog-clear strobes, CPU writes and ALU enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstN | input | 1 | Synchronous core reset, active low |
| sleepStb | input | 1 | One-cycle strobe from the sleep instruction |
| wdtClrStb | input | 1 | One-cycle strobe from the watchdog-clear instruction |
| wdtTimeout | input | 1 | One-cycle watchdog time-out pulse |
| aluFlags | input | 3 | ALU result flags {Z, DC, C} |
| aluFlagEn | input | 3 | Per-flag update enables {Z, DC, C} |
| cmpIn | input | 1 | Live comparator level |
| cpuWrEn | input | 1 | CPU write strobe for the status register |
| cpuWrData | input | PAGE_W+6 | CPU write data |
| statusOut | output | PAGE_W+6 | Register value {cmp, page, T, P, Z, DC, C} |
| pageSel | output | PAGE_W | Program-page select bits |

## Verification
The bench builds the block with the default `PAGE_W` of 2, which gives the 8-bit layout. At that width every page value, 0 to 3, can be reached by a CPU write. The directed cases cover each pair of colliding strobes (time-out with sleep, time-out with watchdog-clear, sleep with watchdog-clear, CPU write with ALU enables). They also cover strobes and writes that arrive during the core reset. A seeded random run then mixes all inputs, including occasional core resets, against a reference model written from the requirements.

// File: rtl/mcu_status_pkg.sv
package mcu_status_pkg;

  localparam int NUM_FLAGS = 3;
  localparam int C_POS     = 0;
  localparam int DC_POS    = 1;
  localparam int Z_POS     = 2;
  localparam int P_POS     = 3;
  localparam int T_POS     = 4;
  localparam int PAGE_LO   = 5;

  typedef struct packed {
    logic                 rstClr;
    logic                 tSet;
    logic                 tClr;
    logic                 pSet;
    logic                 pClr;
    logic                 pageLd;
    logic [NUM_FLAGS-1:0] flagLd;
    logic                 fromCpu;
  } statusCtl_t;

endpackage

// File: rtl/mcu_status_ctrl.sv
module mcu_status_ctrl
  import mcu_status_pkg::*;
(
  input  logic                 rstN,
  input  logic                 sleepStb,
  input  logic                 wdtClrStb,
  input  logic                 wdtTimeout,
  input  logic [NUM_FLAGS-1:0] aluFlagEn,
  input  logic                 cpuWrEn,
  output statusCtl_t           ctl
);

  logic runOk;

  assign runOk = rstN;

  always_comb begin
    ctl         = '0;
    ctl.rstClr  = !rstN;
    // time-out dominates every other source acting on T
    ctl.tClr    = wdtTimeout;
    ctl.tSet    = runOk && (sleepStb || wdtClrStb) && !wdtTimeout;
    // sleep dominates watchdog-clear for P
    ctl.pClr    = runOk && sleepStb;
    ctl.pSet    = runOk && wdtClrStb && !sleepStb;
    ctl.pageLd  = runOk && cpuWrEn;
    ctl.fromCpu = cpuWrEn;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      ctl.flagLd[i] = runOk && (cpuWrEn || aluFlagEn[i]);
    end
  end

endmodule

// File: rtl/mcu_status_dp.sv
module mcu_status_dp
  import mcu_status_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic                 clk,
  input  logic                 porN,
  input  statusCtl_t           ctl,
  input  logic [NUM_FLAGS-1:0] aluFlags,
  input  logic [NUM_FLAGS-1:0] cpuFlags,
  input  logic [PAGE_W-1:0]    cpuPage,
  output logic [PAGE_W-1:0]    pageQ,
  output logic                 tQ,
  output logic                 pQ,
  output logic [NUM_FLAGS-1:0] flagQ
);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)             pageQ <= '0;
    else if (ctl.rstClr)   pageQ <= '0;
    else if (ctl.pageLd)   pageQ <= cpuPage;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)           tQ <= 1'b1;
    else if (ctl.tClr)   tQ <= 1'b0;
    else if (ctl.tSet)   tQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)           pQ <= 1'b1;
    else if (ctl.pClr)   pQ <= 1'b0;
    else if (ctl.pSet)   pQ <= 1'b1;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)              flagQ[i] <= 1'b0;
      else if (ctl.rstClr)    flagQ[i] <= 1'b0;
      else if (ctl.flagLd[i]) flagQ[i] <= ctl.fromCpu ? cpuFlags[i] : aluFlags[i];
    end
  end

endmodule

// File: rtl/mcu_status_reg.sv
module mcu_status_reg
  import mcu_status_pkg::*;
#(
  parameter int PAGE_W = 2,
  localparam int REG_W = PAGE_W + 6
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 rstN,
  input  logic                 sleepStb,
  input  logic                 wdtClrStb,
  input  logic                 wdtTimeout,
  input  logic [NUM_FLAGS-1:0] aluFlags,
  input  logic [NUM_FLAGS-1:0] aluFlagEn,
  input  logic                 cmpIn,
  input  logic                 cpuWrEn,
  input  logic [REG_W-1:0]     cpuWrData,
  output logic [REG_W-1:0]     statusOut,
  output logic [PAGE_W-1:0]    pageSel
);

  localparam int CMP_POS = REG_W - 1;
  localparam int PAGE_HI = PAGE_LO + PAGE_W - 1;

  statusCtl_t           ctl;
  logic [PAGE_W-1:0]    pageQ;
  logic                 tQ;
  logic                 pQ;
  logic [NUM_FLAGS-1:0] flagQ;

  mcu_status_ctrl u_ctrl (
    .rstN       (rstN),
    .sleepStb   (sleepStb),
    .wdtClrStb  (wdtClrStb),
    .wdtTimeout (wdtTimeout),
    .aluFlagEn  (aluFlagEn),
    .cpuWrEn    (cpuWrEn),
    .ctl        (ctl)
  );

  mcu_status_dp #(.PAGE_W(PAGE_W)) u_dp (
    .clk      (clk),
    .porN     (porN),
    .ctl      (ctl),
    .aluFlags (aluFlags),
    .cpuFlags (cpuWrData[Z_POS:C_POS]),
    .cpuPage  (cpuWrData[PAGE_HI:PAGE_LO]),
    .pageQ    (pageQ),
    .tQ       (tQ),
    .pQ       (pQ),
    .flagQ    (flagQ)
  );

  assign statusOut = {cmpIn, pageQ, tQ, pQ, flagQ};
  assign pageSel   = pageQ;

  // CMP_POS documents the live bit position
  logic unusedPos;
  assign unusedPos = ^{CMP_POS[0]};

endmodule

// File: rtl/mcu_status_chk.sv
module mcu_status_chk
  import mcu_status_pkg::*;
#(
  parameter int PAGE_W = 2,
  localparam int REG_W = PAGE_W + 6
) (
  input logic                 clk,
  input logic                 porN,
  input logic                 rstN,
  input logic                 sleepStb,
  input logic                 wdtClrStb,
  input logic                 wdtTimeout,
  input logic [NUM_FLAGS-1:0] aluFlagEn,
  input logic                 cpuWrEn,
  input logic [REG_W-1:0]     cpuWrData,
  input logic [REG_W-1:0]     statusOut,
  input logic [PAGE_W-1:0]    pageSel
);

  localparam int PAGE_HI = PAGE_LO + PAGE_W - 1;

  a_r2_timeout_clears_t: assert property (@(posedge clk) disable iff (!porN)
    wdtTimeout |=> !statusOut[T_POS]);

  a_r3_sleep_sets_t_clears_p: assert property (@(posedge clk) disable iff (!porN)
    (rstN && sleepStb && !wdtTimeout) |=> (statusOut[T_POS] && !statusOut[P_POS]));

  a_r4_wdtclr_sets_p: assert property (@(posedge clk) disable iff (!porN)
    (rstN && wdtClrStb && !sleepStb) |=> statusOut[P_POS]);

  a_r6_tp_ignore_write: assert property (@(posedge clk) disable iff (!porN)
    (cpuWrEn && !sleepStb && !wdtClrStb && !wdtTimeout)
      |=> (statusOut[T_POS:P_POS] == $past(statusOut[T_POS:P_POS])));

  a_r7_write_wins_flags: assert property (@(posedge clk) disable iff (!porN)
    (rstN && cpuWrEn) |=> (statusOut[Z_POS:C_POS] == $past(cpuWrData[Z_POS:C_POS])));

  a_r10_core_reset_clears: assert property (@(posedge clk) disable iff (!porN)
    !rstN |=> (pageSel == '0 && statusOut[Z_POS:C_POS] == '0));

  a_r10_core_reset_keeps_p: assert property (@(posedge clk) disable iff (!porN)
    !rstN |=> (statusOut[P_POS] == $past(statusOut[P_POS])));

  a_r9_page_write: assert property (@(posedge clk) disable iff (!porN)
    (rstN && cpuWrEn) |=> (statusOut[PAGE_HI:PAGE_LO] == $past(cpuWrData[PAGE_HI:PAGE_LO])));

endmodule

bind mcu_status_reg mcu_status_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .porN       (porN),
  .rstN       (rstN),
  .sleepStb   (sleepStb),
  .wdtClrStb  (wdtClrStb),
  .wdtTimeout (wdtTimeout),
  .aluFlagEn  (aluFlagEn),
  .cpuWrEn    (cpuWrEn),
  .cpuWrData  (cpuWrData),
  .statusOut  (statusOut),
  .pageSel    (pageSel)
);

// File: tb/mcu_status_reg_tb.sv
module mcu_status_reg_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       rstN = 1'b1;
  logic       sleepStb = 1'b0;
  logic       wdtClrStb = 1'b0;
  logic       wdtTimeout = 1'b0;
  logic [2:0] aluFlags = '0;
  logic [2:0] aluFlagEn = '0;
  logic       cmpIn = 1'b0;
  logic       cpuWrEn = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] statusOut;
  logic [1:0] pageSel;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic       mT, mP;
  logic [1:0] mPage;
  logic [2:0] mFl;

  typedef struct {
    logic [7:0] st;
    logic [1:0] pg;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcu_status_reg u_dut (
    .clk        (clk),
    .porN       (porN),
    .rstN       (rstN),
    .sleepStb   (sleepStb),
    .wdtClrStb  (wdtClrStb),
    .wdtTimeout (wdtTimeout),
    .aluFlags   (aluFlags),
    .aluFlagEn  (aluFlagEn),
    .cmpIn      (cmpIn),
    .cpuWrEn    (cpuWrEn),
    .cpuWrData  (cpuWrData),
    .statusOut  (statusOut),
    .pageSel    (pageSel)
  );

  task automatic modelStep();
    if (!porN) begin
      mT = 1'b1; mP = 1'b1; mPage = '0; mFl = '0;
    end else if (!rstN) begin
      if (wdtTimeout) mT = 1'b0;
      mPage = '0; mFl = '0;
    end else begin
      if (wdtTimeout) mT = 1'b0;
      else if (sleepStb || wdtClrStb) mT = 1'b1;
      if (sleepStb) mP = 1'b0;
      else if (wdtClrStb) mP = 1'b1;
      if (cpuWrEn) begin
        mPage = cpuWrData[6:5];
        mFl   = cpuWrData[2:0];
      end else begin
        for (int i = 0; i < 3; i++) if (aluFlagEn[i]) mFl[i] = aluFlags[i];
      end
    end
  endtask

  function automatic item_t expItem(string tag);
    item_t it;
    it.st  = {cmpIn, mPage, mT, mP, mFl};
    it.pg  = mPage;
    it.tag = tag;
    return it;
  endfunction

  // driver: one clock with current inputs, push expected result
  task automatic cyc(string tag);
    @(posedge clk);
    modelStep();
    #1;
    sbq.push_back(expItem(tag));
    #3;
    sleepStb = 0; wdtClrStb = 0; wdtTimeout = 0;
    aluFlagEn = '0; cpuWrEn = 0; rstN = 1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (statusOut !== it.st || pageSel !== it.pg) begin
          errors++;
          $display("FAIL %s: statusOut=%h pageSel=%0d expected statusOut=%h pageSel=%0d",
                   it.tag, statusOut, pageSel, it.st, it.pg);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    // R1: power-on state, T=P=1, others 0 -> 8'h18
    porN = 0;
    cyc("R1 power-on state");
    #1;
    checks++;
    if (statusOut !== 8'h18) begin
      errors++;
      $display("FAIL R1 async por value: actual=%h expected=18", statusOut);
    end
    @(negedge clk); porN = 1;
    cyc("R1 idle after por");

    // R3 sleep
    sleepStb = 1; cyc("R3 sleep T=1 P=0");
    // R4 watchdog clear
    wdtClrStb = 1; cyc("R4 wdt clear T=1 P=1");
    // R2 timeout
    wdtTimeout = 1; cyc("R2 timeout clears T");
    // R2 priority over sleep
    wdtTimeout = 1; sleepStb = 1; cyc("R2 timeout beats sleep");
    // R2 priority over wdt clear
    wdtTimeout = 1; wdtClrStb = 1; cyc("R2 timeout beats wdt clear");
    // R4 sleep and clear together
    sleepStb = 1; wdtClrStb = 1; cyc("R4 sleep wins P");

    // R5 per-flag enables
    aluFlags = 3'b111; aluFlagEn = 3'b100; cyc("R5 Z only");
    aluFlags = 3'b111; aluFlagEn = 3'b001; cyc("R5 C only");
    aluFlags = 3'b010; aluFlagEn = 3'b111; cyc("R5 all flags");
    aluFlags = 3'b111; aluFlagEn = 3'b000; cyc("R5 no enable holds");

    // R6 write with ignored bits
    cpuWrEn = 1; cpuWrData = 8'hFF; cyc("R6 write all ones");
    cpuWrEn = 1; cpuWrData = 8'h58; cyc("R6 write page2 T/P bits ignored");
    // R7 write vs ALU
    cpuWrEn = 1; cpuWrData = 8'h25; aluFlags = 3'b010; aluFlagEn = 3'b111;
    cyc("R7 write beats alu");

    // R8 live comparator
    cmpIn = 1; cyc("R8 comparator high");
    #2; cmpIn = 0; #1;
    checks++;
    if (statusOut[7] !== 1'b0) begin
      errors++;
      $display("FAIL R8 combinational: actual=%b expected=0", statusOut[7]);
    end
    cmpIn = 1; #1;
    checks++;
    if (statusOut[7] !== 1'b1) begin
      errors++;
      $display("FAIL R8 combinational: actual=%b expected=1", statusOut[7]);
    end

    // R9 page values
    for (int pg = 0; pg < 4; pg++) begin
      cpuWrEn = 1; cpuWrData = 8'(pg << 5); cyc("R9 page select");
    end

    // R10 core reset
    cpuWrEn = 1; cpuWrData = 8'h67; cyc("R10 preload");
    wdtClrStb = 1; cyc("R10 preload T/P");
    rstN = 0; sleepStb = 1; cpuWrEn = 1; cpuWrData = 8'hFF; aluFlagEn = 3'b111;
    aluFlags = 3'b111;
    cyc("R10 reset ignores strobes and clears");
    rstN = 0; wdtTimeout = 1; cyc("R2 R10 timeout during core reset");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      rstN       = (r < 5) ? 1'b0 : 1'b1;
      sleepStb   = ($urandom_range(0, 5) == 0);
      wdtClrStb  = ($urandom_range(0, 5) == 0);
      wdtTimeout = ($urandom_range(0, 7) == 0);
      aluFlags   = 3'($urandom);
      aluFlagEn  = 3'($urandom);
      cpuWrEn    = ($urandom_range(0, 3) == 0);
      cpuWrData  = 8'($urandom);
      cmpIn      = 1'($urandom);
      cyc("R2 R3 R4 R5 R6 R7 R10 random mix");
    end

    // R1 second power-on mid-run
    @(negedge clk); porN = 0;
    #1;
    checks++;
    if (statusOut[6:0] !== 7'h18) begin
      errors++;
      $display("FAIL R1 mid-run por: actual=%h expected=18", statusOut[6:0]);
    end
    cyc("R1 por held");
    @(negedge clk); porN = 1;
    cyc("R1 after second por");

    @(posedge clk); #5;
    finishRun();
  end

endmodule